// File: doc/BRIEF.md
# Watchdog Timer with Partial Prescaler Clear

This block is a watchdog built from one free-running binary chain: a prescaler section followed by a counter section, both stepped by the oscillator-derived clock. If software does not service it, the chain reaches a terminal value and the block raises a reset request. Software services the watchdog by writing any data to one fixed bus address. That write clears every chain stage above the lowest four. The lowest four stages keep running, so the time to the next timeout depends on where they stood when the write arrived.

A configuration input selects the timeout. The long timeout is taken from the whole chain. The short timeout is taken from a lower tap of the chain. In both cases the timeout is a power of two minus sixteen cycles, counted from a full clear. The whole chain is forced to zero by internal reset sources, by a reset vector fetch and by entry into stop mode. A configuration disable input stops the block from issuing any new request. Each overflow sets a cause flag. The flag stays set until it is read or until power-on reset.

Top module: `wdt_watchdog`

## Requirements
- R1: With `rateLong` high, the reset request first rises exactly 2^(PRE_BITS+CNT_BITS) − 16 cycles after the chain was last fully cleared. With the bench parameters, PRE_BITS=6 and CNT_BITS=3, this is 496 cycles.
- R2: With `rateLong` low, the request first rises exactly 2^SHORT_TAP − 16 cycles after a full clear. With the bench parameter SHORT_TAP=7, this is 112 cycles.
- R3: A bus write to address `SVC_ADDR` (default 16'hFFFF) with any data clears all chain stages above the lowest four. The lowest four stages keep counting. A write in the cycle where the chain holds value d therefore gives a timeout of T − ((d+1) mod 16) cycles from the following cycle, where T is the selected timeout. This also holds when d = T−1, one cycle before overflow, and in that case no request is raised.
- R4: A bus write to any address other than `SVC_ADDR` has no effect on the timeout.
- R5: A one-cycle pulse on `intRst`, `vecFetch` or `stopEntry` clears the whole chain, so the next timeout is a full T cycles.
- R6: While `copDisable` is high and no request pulse is already in progress, no request is raised and the flag is not set. The chain is held at zero, so a full T cycles follow once `copDisable` falls.
- R7: A request is high for exactly 4 (`PULSE_LEN`) consecutive cycles. The chain is held clear during the request, so the next timeout counts from zero.
- R8: An overflow sets `copFlag`. The flag holds until a `statusRd` strobe, which clears it in the next cycle.
- R9: While `rstN` is low, `copRstReq` and `copFlag` are low and the chain is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-derived clock |
| rstN | input | 1 | Active-low power-on reset, asynchronous |
| rateLong | input | 1 | Selects the timeout: 1 for the long timeout, 0 for the short timeout |
| copDisable | input | 1 | Configuration disable; 1 blocks new requests |
| busWr | input | 1 | Bus write strobe |
| busAddr | input | ADDR_W | Bus write address |
| stopEntry | input | 1 | Pulses when a stop instruction executes |
| vecFetch | input | 1 | Pulses on a reset vector fetch |
| intRst | input | 1 | Internal reset sources, combined |
| statusRd | input | 1 | Read strobe of the cause flag |
| copRstReq | output | 1 | Reset request pulse |
| copFlag | output | 1 | Watchdog cause flag |

## Verification
The bench measures the exact number of cycles from a known chain position to the rising edge of the request. It does this for both rate settings, from power-on, after a full clear, and after service writes placed at random and directed chain positions. Service positions with different low-nibble values separate a correct partial clear from a full clear, because a full clear would always give T. The one-cycle-before-overflow service and the low nibble of 15 test the edges of the terminal compare and of the carry handling. Writes to wrong addresses, each clearing source and the disable input are each followed by a timing measurement. That measurement shows whether the chain was left alone or cleared. Pulse width and the flag's set, hold and clear behaviour are checked after every timeout.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  // Strobes that the control sends to the chain datapath.
  typedef struct packed {
    logic clrAll;  // force the whole chain to zero
    logic svc;     // clear the upper stages, keep the low stages running
  } wdtStrobe_t;
endpackage

// File: rtl/wdt_chain.sv
module wdt_chain
  import wdt_pkg::*;
#(
  parameter int PRE_BITS  = 12,
  parameter int CNT_BITS  = 6,
  parameter int KEEP_BITS = 4,
  parameter int SHORT_TAP = 13
) (
  input  logic       clk,
  input  logic       rstN,
  input  wdtStrobe_t strobe,
  input  logic       rateLong,
  output logic       ovfHit
);
  localparam int W = PRE_BITS + CNT_BITS;
  localparam logic [W-1:0] LONG_TERM =
    {{(W - KEEP_BITS){1'b1}}, {KEEP_BITS{1'b0}}};
  localparam logic [SHORT_TAP-1:0] SHORT_TERM =
    {{(SHORT_TAP - KEEP_BITS){1'b1}}, {KEEP_BITS{1'b0}}};

  logic [W-1:0]         chain;
  logic [KEEP_BITS-1:0] lowNext;
  logic                 longHit;
  logic                 shortHit;

  assign lowNext = chain[KEEP_BITS-1:0] + 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chain <= '0;
    end else if (strobe.clrAll) begin
      chain <= '0;
    end else if (strobe.svc) begin
      chain <= {{(W - KEEP_BITS){1'b0}}, lowNext};
    end else begin
      chain <= chain + 1'b1;
    end
  end

  // Terminal compare on the full chain or on the lower tap.
  generate
    if (SHORT_TAP < W) begin : g_tap
      assign shortHit = (chain[SHORT_TAP-1:0] == SHORT_TERM);
    end else begin : g_tapFull
      assign shortHit = (chain == LONG_TERM);
    end
  endgenerate

  assign longHit = (chain == LONG_TERM);
  assign ovfHit  = rateLong ? longHit : shortHit;

  // R5 / R7: a full clear leaves the chain at zero.
  p_full_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrAll |=> (chain == '0));
  // R3: service empties the upper stages.
  p_svc_upper_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.svc && !strobe.clrAll) |=> (chain[W-1:KEEP_BITS] == '0));
  // R3: the low stages keep counting through a service.
  p_svc_low_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.svc && !strobe.clrAll) |=>
      (chain[KEEP_BITS-1:0] == KEEP_BITS'($past(chain[KEEP_BITS-1:0]) + 1'b1)));
endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] SVC_ADDR  = '1,
  parameter int                PULSE_LEN = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              copDisable,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              stopEntry,
  input  logic              vecFetch,
  input  logic              intRst,
  input  logic              statusRd,
  input  logic              ovfHit,
  output wdtStrobe_t        strobe,
  output logic              copRstReq,
  output logic              copFlag
);
  localparam int PW = $clog2(PULSE_LEN + 1);

  logic [PW-1:0] pulseLeft;
  logic          busy;
  logic          ovf;

  assign ovf  = ovfHit && !copDisable;
  assign busy = (pulseLeft != '0);

  assign strobe.clrAll = intRst || vecFetch || stopEntry || copDisable || ovf || busy;
  assign strobe.svc    = busWr && (busAddr == SVC_ADDR);

  // The request rises in the overflow cycle itself; a counter stretches it.
  assign copRstReq = ovf || busy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pulseLeft <= '0;
    end else if (ovf) begin
      pulseLeft <= PW'(PULSE_LEN - 1);
    end else if (busy) begin
      pulseLeft <= pulseLeft - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      copFlag <= 1'b0;
    end else if (ovf) begin
      copFlag <= 1'b1;
    end else if (statusRd) begin
      copFlag <= 1'b0;
    end
  end

  // R6: no new request while disabled.
  p_no_new_rst_r6: assert property (@(posedge clk) disable iff (!rstN)
    (copDisable && !busy) |-> !copRstReq);
  // R7: a request never lasts a single cycle.
  p_pulse_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(copRstReq) |=> copRstReq);
  // R7: the chain restarts from zero, so no request follows right after one.
  p_pulse_gap_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(copRstReq) |=> !copRstReq);
  // R8: overflow sets the flag.
  p_flag_set_r8: assert property (@(posedge clk) disable iff (!rstN)
    ovf |=> copFlag);
  // R8: the flag holds without a read.
  p_flag_keep_r8: assert property (@(posedge clk) disable iff (!rstN)
    (copFlag && !statusRd) |=> copFlag);
endmodule

// File: rtl/wdt_watchdog.sv
module wdt_watchdog
  import wdt_pkg::*;
#(
  parameter int                PRE_BITS  = 12,
  parameter int                CNT_BITS  = 6,
  parameter int                KEEP_BITS = 4,
  parameter int                SHORT_TAP = 13,
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] SVC_ADDR  = 16'hFFFF,
  parameter int                PULSE_LEN = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rateLong,
  input  logic              copDisable,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              stopEntry,
  input  logic              vecFetch,
  input  logic              intRst,
  input  logic              statusRd,
  output logic              copRstReq,
  output logic              copFlag
);
  wdtStrobe_t strobe;
  logic       ovfHit;

  wdt_ctrl #(
    .ADDR_W   (ADDR_W),
    .SVC_ADDR (SVC_ADDR),
    .PULSE_LEN(PULSE_LEN)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .copDisable(copDisable),
    .busWr     (busWr),
    .busAddr   (busAddr),
    .stopEntry (stopEntry),
    .vecFetch  (vecFetch),
    .intRst    (intRst),
    .statusRd  (statusRd),
    .ovfHit    (ovfHit),
    .strobe    (strobe),
    .copRstReq (copRstReq),
    .copFlag   (copFlag)
  );

  wdt_chain #(
    .PRE_BITS (PRE_BITS),
    .CNT_BITS (CNT_BITS),
    .KEEP_BITS(KEEP_BITS),
    .SHORT_TAP(SHORT_TAP)
  ) u_chain (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .rateLong(rateLong),
    .ovfHit  (ovfHit)
  );
endmodule

// File: tb/wdt_watchdog_bench.sv
module wdt_watchdog_bench;
  localparam int TERM_L = 496;  // 2^9 - 16
  localparam int TERM_S = 112;  // 2^7 - 16
  localparam logic [15:0] SVC = 16'hFFFF;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rateLong = 1'b1;
  logic        copDisable = 1'b0;
  logic        busWr = 1'b0;
  logic [15:0] busAddr = '0;
  logic        stopEntry = 1'b0;
  logic        vecFetch = 1'b0;
  logic        intRst = 1'b0;
  logic        statusRd = 1'b0;
  logic        copRstReq;
  logic        copFlag;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  wdt_watchdog #(
    .PRE_BITS(6), .CNT_BITS(3), .KEEP_BITS(4), .SHORT_TAP(7),
    .ADDR_W(16), .SVC_ADDR(16'hFFFF), .PULSE_LEN(4)
  ) u_wdt_watchdog (
    .clk(clk), .rstN(rstN), .rateLong(rateLong), .copDisable(copDisable),
    .busWr(busWr), .busAddr(busAddr), .stopEntry(stopEntry),
    .vecFetch(vecFetch), .intRst(intRst), .statusRd(statusRd),
    .copRstReq(copRstReq), .copFlag(copFlag)
  );

  function automatic int termOf(logic lng);
    return lng ? TERM_L : TERM_S;
  endfunction

  function automatic int expAfterSvc(int term, int d, bit hit);
    return hit ? term - ((d + 1) % 16) : term - (d + 1);
  endfunction

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Counts low cycles to the rise of the request, then its width.
  // Leaves off at a negedge where the chain is zero.
  task automatic measure(output int n, output int width);
    n = 0;
    width = 0;
    while (!copRstReq && n < 2000) begin
      n++;
      @(negedge clk);
    end
    while (copRstReq && width < 20) begin
      width++;
      @(negedge clk);
    end
  endtask

  task automatic readFlag();
    statusRd = 1'b1;
    @(negedge clk);
    statusRd = 1'b0;
  endtask

  task automatic pulseClear(int which);
    case (which)
      0: intRst = 1'b1;
      1: vecFetch = 1'b1;
      default: stopEntry = 1'b1;
    endcase
    @(negedge clk);
    intRst = 1'b0;
    vecFetch = 1'b0;
    stopEntry = 1'b0;
  endtask

  // From a zero chain: wait d cycles, write, then time the next overflow.
  task automatic svcCase(string req, logic lng, int d, logic [15:0] addr);
    int n, w;
    rateLong = lng;
    pulseClear(0);
    repeat (d) @(negedge clk);
    chk({req, " no request before write"}, int'(copRstReq), 0);
    busWr = 1'b1;
    busAddr = addr;
    @(negedge clk);
    busWr = 1'b0;
    measure(n, w);
    chk({req, " timeout after write"}, n, expAfterSvc(termOf(lng), d, addr == SVC));
    chk("R7 pulse width", w, 4);
    readFlag();
  endtask

  initial begin
    int n, w, hiCount;
    void'($urandom(32'd777));

    // R9: reset state
    repeat (3) @(negedge clk);
    chk("R9 request in reset", int'(copRstReq), 0);
    chk("R9 flag in reset", int'(copFlag), 0);
    rstN = 1'b1;

    // R1: long timeout from power-on, R7 width, R8 flag
    measure(n, w);
    chk("R1 long timeout", n, TERM_L);
    chk("R7 pulse width", w, 4);
    chk("R8 flag set", int'(copFlag), 1);
    repeat (10) @(negedge clk);
    chk("R8 flag held", int'(copFlag), 1);
    readFlag();
    chk("R8 flag cleared by read", int'(copFlag), 0);

    // R2: short timeout
    rateLong = 1'b0;
    pulseClear(0);
    measure(n, w);
    chk("R2 short timeout", n, TERM_S);
    chk("R7 pulse width short", w, 4);
    readFlag();

    // R3: directed service positions
    svcCase("R3 long one before overflow", 1'b1, TERM_L - 1, SVC);
    svcCase("R3 short one before overflow", 1'b0, TERM_S - 1, SVC);
    svcCase("R3 low nibble 15", 1'b1, 15, SVC);
    svcCase("R3 mid position", 1'b1, 203, SVC);
    // R4: wrong address
    svcCase("R4 wrong address", 1'b1, 40, 16'hFFFE);
    svcCase("R4 zero address", 1'b0, 70, 16'h0000);

    // R5: each clearing source
    for (int s = 0; s < 3; s++) begin
      rateLong = 1'b1;
      pulseClear(0);
      repeat (200 + s) @(negedge clk);
      pulseClear(s);
      measure(n, w);
      chk($sformatf("R5 full clear source %0d", s), n, TERM_L);
      readFlag();
    end

    // R6: disable
    rateLong = 1'b0;
    copDisable = 1'b1;
    hiCount = 0;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (copRstReq) hiCount++;
    end
    chk("R6 no request while disabled", hiCount, 0);
    chk("R6 flag untouched while disabled", int'(copFlag), 0);
    copDisable = 1'b0;
    measure(n, w);
    chk("R6 full timeout after enable", n, TERM_S);
    readFlag();

    // R3 / R4: random positions, rates and addresses
    for (int i = 0; i < 24; i++) begin
      logic lng;
      int d;
      logic [15:0] a;
      lng = 1'($urandom % 2);
      d = int'($urandom % termOf(lng));
      a = ($urandom % 3 != 0) ? SVC : 16'($urandom_range(0, 16'hFFFE));
      svcCase((a == SVC) ? "R3 random service" : "R4 random wrong address", lng, d, a);
    end

    // R9: power-on reset clears a set flag
    rateLong = 1'b0;
    pulseClear(0);
    measure(n, w);
    chk("R8 flag set before reset", int'(copFlag), 1);
    rstN = 1'b0;
    @(negedge clk);
    chk("R9 flag cleared by reset", int'(copFlag), 0);
    chk("R9 request low in reset", int'(copRstReq), 0);
    rstN = 1'b1;
    measure(n, w);
    chk("R9 chain zero after reset", n, TERM_S);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=hang expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule